// File: doc/BRIEF.md
# Half-Warp Access Coalescer

This block sits between the load/store issue stage of a SIMD core and its memory request port. It takes the requests of one half-warp in a single transfer: a byte address and an enable bit for each of 16 lanes. Each lane accesses one 4-byte word. The block decides whether the enabled lanes form one aligned, strictly sequential segment. If they do, it sends out a single merged transaction that carries the segment base and a word-enable mask. If they do not, it sends out one transaction per enabled lane, one per handshake.

Requests enter through `req_valid_i`/`req_ready_o`. Transactions leave through `txn_valid_o`/`txn_ready_i`. Only one half-warp is in flight at a time. Returned data, DRAM timing and caching are handled elsewhere.

Top module: `halfwarp_coalescer`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `txn_valid_o` is 0.
- R2: A request merges when three conditions hold. First, at least one lane is enabled. Second, base is the address of the lowest enabled lane with its low 6 bits cleared. Third, every enabled lane k has address base + 4*k. A merged request produces exactly one transaction with `txn_merged_o`=1, `txn_addr_o`=base and `txn_mask_o`=the enable bits (bit k is lane k).
- R3: If an enabled lane's address is off its sequential slot by any amount, the request is split. This covers a start that is not a multiple of 64 and addresses that are not word aligned.
- R4: A permuted lane-to-word mapping is split, even when it covers exactly the same 64-byte segment.
- R5: Disabled lanes do not affect the merge decision, whatever addresses they carry.
- R6: A split request produces one transaction per enabled lane, in ascending lane order, with disabled lanes skipped. Each transaction has `txn_merged_o`=0, `txn_addr_o`=that lane's address and `txn_mask_o` with only that lane's bit set.
- R7: While `txn_valid_o` is 1 and `txn_ready_i` is 0, the transaction outputs hold their values into the next cycle.
- R8: An accepted request with no enabled lane produces no transaction, and `req_ready_o` is 1 again in the next cycle.
- R9: `req_ready_o` is 0 from acceptance until the last transaction has been handed off. It returns to 1 in the cycle after that handoff, and is never 1 while `txn_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Half-warp request present |
| req_ready_o | output | 1 | Block can take a request |
| req_addr_i | input | LANES*ADDR_W | Lane byte addresses, lane k at bits [k*ADDR_W +: ADDR_W] |
| req_active_i | input | LANES | Lane enable bits |
| txn_valid_o | output | 1 | Transaction present |
| txn_ready_i | input | 1 | Downstream takes the transaction |
| txn_merged_o | output | 1 | 1 for a merged segment, 0 for a single lane |
| txn_addr_o | output | ADDR_W | Segment base or lane address |
| txn_mask_o | output | LANES | Word-enable mask |

## Verification
The bench builds the block with its defaults: 16 lanes, 32-bit addresses and 4-byte words, which gives 64-byte segments. With these values the bench can reach the full set of lane-mask patterns: empty, single-lane, sparse and full masks. It can also place segment bases near the top of the address space. Random back-pressure on `txn_ready_i` brings the hold and ordering behaviour of long split sequences within reach.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MERGE = 2'd1,
    ST_SPLIT = 2'd2
  } hwc_state_e;
endpackage

// File: rtl/hwc_lane_pick.sv
module hwc_lane_pick #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hwc_classify.sv
module hwc_classify #(
  parameter int LANES      = 16,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic [LANES*ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]        act_i,
  output logic                    merge_o,
  output logic [ADDR_W-1:0]       base_o
);
  localparam int SEG_BYTES = LANES * WORD_BYTES;
  localparam int IDX_W     = $clog2(LANES);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(SEG_BYTES - 1);

  logic [IDX_W-1:0] first_idx;
  logic             first_any;
  logic [LANES-1:0] hit;

  hwc_lane_pick #(.N(LANES)) u_first (
    .vec_i (act_i),
    .idx_o (first_idx),
    .any_o (first_any)
  );

  assign base_o = addr_i[first_idx*ADDR_W +: ADDR_W] & ~OFF_MASK;

  for (genvar k = 0; k < LANES; k++) begin : g_slot
    assign hit[k] = !act_i[k] ||
                    (addr_i[k*ADDR_W +: ADDR_W] == base_o + ADDR_W'(k * WORD_BYTES));
  end

  assign merge_o = first_any && (&hit);
endmodule

// File: rtl/halfwarp_coalescer.sv
module halfwarp_coalescer
  import hwc_pkg::*;
#(
  parameter int LANES      = 16,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [LANES*ADDR_W-1:0] req_addr_i,
  input  logic [LANES-1:0]        req_active_i,
  output logic                    txn_valid_o,
  input  logic                    txn_ready_i,
  output logic                    txn_merged_o,
  output logic [ADDR_W-1:0]       txn_addr_o,
  output logic [LANES-1:0]        txn_mask_o
);
  localparam int IDX_W = $clog2(LANES);

  hwc_state_e              state_q;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES-1:0]        act_q, pend_q, cur_bit, pend_nxt;
  logic [ADDR_W-1:0]       base_q, cls_base;
  logic                    cls_merge, cur_any;
  logic [IDX_W-1:0]        cur_idx;

  hwc_classify #(
    .LANES(LANES), .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)
  ) u_cls (
    .addr_i  (req_addr_i),
    .act_i   (req_active_i),
    .merge_o (cls_merge),
    .base_o  (cls_base)
  );

  hwc_lane_pick #(.N(LANES)) u_next (
    .vec_i (pend_q),
    .idx_o (cur_idx),
    .any_o (cur_any)
  );

  assign cur_bit  = LANES'(1) << cur_idx;
  assign pend_nxt = pend_q & ~cur_bit;

  assign req_ready_o  = (state_q == ST_IDLE);
  assign txn_valid_o  = (state_q == ST_MERGE) || ((state_q == ST_SPLIT) && cur_any);
  assign txn_merged_o = (state_q == ST_MERGE);
  assign txn_addr_o   = (state_q == ST_MERGE) ? base_q : addr_q[cur_idx*ADDR_W +: ADDR_W];
  assign txn_mask_o   = (state_q == ST_MERGE) ? act_q : cur_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      act_q   <= '0;
      pend_q  <= '0;
      base_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q <= req_addr_i;
          act_q  <= req_active_i;
          pend_q <= req_active_i;
          base_q <= cls_base;
          if (req_active_i == '0) state_q <= ST_IDLE;
          else if (cls_merge)     state_q <= ST_MERGE;
          else                    state_q <= ST_SPLIT;
        end
        ST_MERGE: if (txn_ready_i) state_q <= ST_IDLE;
        ST_SPLIT: if (txn_ready_i) begin
          pend_q <= pend_nxt;
          if (pend_nxt == '0) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hwc_chk.sv
module hwc_chk #(
  parameter int LANES  = 16,
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [LANES-1:0]  req_active_i,
  input logic              txn_valid_o,
  input logic              txn_ready_i,
  input logic              txn_merged_o,
  input logic [ADDR_W-1:0] txn_addr_o,
  input logic [LANES-1:0]  txn_mask_o
);
  // R7
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && !txn_ready_i |=> txn_valid_o && $stable(txn_addr_o) &&
                                    $stable(txn_mask_o) && $stable(txn_merged_o));
  // R9
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && txn_valid_o));
  // R2
  merged_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && txn_merged_o |-> (txn_addr_o[5:0] == 6'd0) && (txn_mask_o != '0));
  // R6
  split_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && !txn_merged_o |-> $countones(txn_mask_o) == 1);
  // R8
  empty_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && (req_active_i == '0) |=> req_ready_o && !txn_valid_o);
  // R9
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && (req_active_i != '0) |=> !req_ready_o);
endmodule

bind halfwarp_coalescer hwc_chk #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_active_i (req_active_i),
  .txn_valid_o  (txn_valid_o),
  .txn_ready_i  (txn_ready_i),
  .txn_merged_o (txn_merged_o),
  .txn_addr_o   (txn_addr_o),
  .txn_mask_o   (txn_mask_o)
);

// File: tb/halfwarp_coalescer_tb_top.sv
module halfwarp_coalescer_tb_top;
  localparam int L = 16;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            req_valid = 1'b0, txn_ready = 1'b0;
  logic [L*AW-1:0] req_addr = '0;
  logic [L-1:0]    req_act = '0;
  logic            req_ready, txn_valid, txn_merged;
  logic [AW-1:0]   txn_addr;
  logic [L-1:0]    txn_mask;

  halfwarp_coalescer dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_active_i(req_act),
    .txn_valid_o(txn_valid), .txn_ready_i(txn_ready),
    .txn_merged_o(txn_merged), .txn_addr_o(txn_addr), .txn_mask_o(txn_mask)
  );

  int checks = 0, fails = 0;
  logic [AW-1:0] a [L];
  logic [AW-1:0] exp_addr [L];
  logic [L-1:0]  exp_mask [L];
  logic          exp_mrg;
  int            exp_n;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected transaction list from R2..R6
  function automatic void model(input logic [L-1:0] act);
    int first = -1;
    logic [AW-1:0] base;
    bit m;
    exp_n = 0;
    for (int k = 0; k < L; k++) if (act[k] && first < 0) first = k;
    if (first < 0) begin exp_mrg = 1'b0; return; end
    base = a[first] & ~32'h3F;
    m = 1'b1;
    for (int k = 0; k < L; k++) if (act[k] && a[k] != base + 32'(4*k)) m = 1'b0;
    exp_mrg = m;
    if (m) begin
      exp_addr[0] = base; exp_mask[0] = act; exp_n = 1;
    end else begin
      for (int k = 0; k < L; k++) if (act[k]) begin
        exp_addr[exp_n] = a[k]; exp_mask[exp_n] = L'(1) << k; exp_n++;
      end
    end
  endfunction

  task automatic run(input logic [L-1:0] act, input string tag, input int bp);
    int got = 0, guard = 0;
    logic [AW-1:0] h_addr; logic [L-1:0] h_mask; bit held = 0;
    model(act);
    for (int k = 0; k < L; k++) req_addr[k*AW +: AW] = a[k];
    req_act = act; req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    if (exp_n == 0) begin
      // R8
      chk(req_ready && !txn_valid, "R8", {62'd0, req_ready, txn_valid}, 64'h2);
      return;
    end
    while (got < exp_n && guard < 200) begin
      guard++;
      chk(!req_ready, "R9 busy", {63'd0, req_ready}, 64'd0);
      if (held) begin
        // R7
        chk(txn_valid && txn_addr == h_addr && txn_mask == h_mask, "R7",
            {txn_addr, 16'd0, txn_mask}, {h_addr, 16'd0, h_mask});
      end
      txn_ready = ($urandom % 100) >= bp;
      if (txn_valid && txn_ready) begin
        chk(txn_merged == exp_mrg, {tag, " merged"}, {63'd0, txn_merged}, {63'd0, exp_mrg});
        chk(txn_addr == exp_addr[got] && txn_mask == exp_mask[got], tag,
            {txn_addr, 16'd0, txn_mask}, {exp_addr[got], 16'd0, exp_mask[got]});
        got++; held = 0;
      end else if (txn_valid) begin
        held = 1; h_addr = txn_addr; h_mask = txn_mask;
      end
      @(posedge clk); @(negedge clk);
      txn_ready = 1'b0;
    end
    chk(got == exp_n, {tag, " count"}, 64'(got), 64'(exp_n));
    // R9
    chk(req_ready && !txn_valid, "R9 release", {62'd0, req_ready, txn_valid}, 64'h2);
  endtask

  task automatic fill_seq(input logic [AW-1:0] base);
    for (int k = 0; k < L; k++) a[k] = base + 32'(4*k);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [AW-1:0] t;
    int i, j;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R1
    chk(req_ready && !txn_valid, "R1", {62'd0, req_ready, txn_valid}, 64'h2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !txn_valid, "R1", {62'd0, req_ready, txn_valid}, 64'h2);

    fill_seq(32'h0000_1000); run(16'hFFFF, "R2 full", 0);
    fill_seq(32'hFFFF_FFC0); run(16'hFFFF, "R2 top", 40);
    fill_seq(32'h0000_2044); run(16'hFFFF, "R3 misaligned", 30);
    fill_seq(32'h0000_3000); a[5] = a[5] + 1; run(16'h00F0, "R3 unaligned word", 0);
    fill_seq(32'h0000_4000); t = a[2]; a[2] = a[9]; a[9] = t; run(16'hFFFF, "R4 permuted", 50);
    fill_seq(32'h0000_5000); a[0] = 32'hDEAD_BEEF; a[15] = 32'h1234_5678;
    run(16'h7FFE, "R5 ignored lanes", 20);
    fill_seq(32'h0000_6000); run(16'h0100, "R5 single lane", 0);
    for (int k = 0; k < L; k++) a[k] = 32'h0000_7000 + 32'(64*k);
    run(16'hA5A5, "R6 strided", 60);
    run(16'h0000, "R8 empty", 0);
    fill_seq(32'h0000_8000); run(16'h8001, "R2 sparse", 0);

    for (int n = 0; n < 300; n++) begin
      logic [L-1:0] act;
      act = L'($urandom);
      if ((n % 7) == 0) act = '0;
      fill_seq({$urandom} & ~32'h3F);
      case ($urandom % 4)
        0: ;
        1: begin i = $urandom % L; a[i] = a[i] + 32'(4 * (1 + $urandom % 3)); end
        2: begin i = $urandom % L; j = $urandom % L; t = a[i]; a[i] = a[j]; a[j] = t; end
        default: for (int k = 0; k < L; k++) a[k] = $urandom;
      endcase
      run(act, "R6 random", $urandom % 70);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule